// File: doc/BRIEF.md
# Lane-Grouped Operand Concatenation Unit

This unit joins a narrow operand and a wide operand into one result word. The join is applied separately to each SIMD sub-word. Each operand is cut into four equal lanes. The narrow operand has 4-bit lanes and the wide operand has 8-bit lanes. A 3-bit boundary mask groups neighbouring lanes into sub-words.

The output is built group by group, starting from the lowest lane. For each group, its narrow-operand lanes are placed first, in rising lane order, and its wide-operand lanes follow. The next group then starts directly above. The result is the per-sub-word concatenation that a partitioned datapath needs, and nothing has to be moved in software.

The unit is purely combinational and has no clock. Any change on an input reaches the output in the same cycle.

Top module: `seg_cat`

## Requirements
- R1: Boundary bit k of `segMask` set means that lane k and lane k+1 belong to different groups. Bit k clear means they belong to the same group. Lanes are numbered from 0 at the least significant end.
- R2: With `segMask` = 3'b000 there is a single group, and `catOut` equals `{wideIn, narrowIn}`.
- R3: With `segMask` = 3'b111 there are four groups. From low to high, `catOut` is N0, W0, N1, W1, N2, W2, N3, W3. Here Nk is `narrowIn[4k+3:4k]` and Wk is `wideIn[8k+7:8k]`.
- R4: With `segMask` = 3'b010, from low to high, `catOut` is N0, N1, W0, W1, N2, N3, W2, W3.
- R5: For any mask, groups are laid out from bit 0 upward. Inside each group, all of its N lanes come first in rising order, then all of its W lanes in rising order. Each mask value gives its own arrangement. For example, 3'b001 gives N0, W0, N1, N2, N3, W1, W2, W3.
- R6: Bits [3:0] of `catOut` always equal N0, whatever the mask.
- R7: Bits [47:40] of `catOut` always equal W3, whatever the mask.
- R8: Lanes are never dropped or overlapped. The number of ones in `catOut` always equals the number of ones in `narrowIn` plus the number in `wideIn`.
- R9: The output depends only on the present inputs. It settles within the same cycle as any input change and keeps no state from earlier inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| narrowIn | input | 16 | Narrow operand, four 4-bit lanes |
| wideIn | input | 32 | Wide operand, four 8-bit lanes |
| segMask | input | 3 | Group boundary mask; bit k splits lane k from lane k+1 |
| catOut | output | 48 | Per-group concatenation |

## Verification
A wrong group start or group length computed inside the unit shifts every lane of that group and of the groups above it. The fault therefore shows at the output as soon as the inputs are applied, with no delay of any kind. A lane steered to the wrong offset either collides with another lane or leaves a gap, so the count of ones no longer matches the inputs. Only a full lane-by-lane compare catches two lanes that are swapped. For that reason the bench checks all eight masks with patterns that give every lane a distinct value.

// File: rtl/seg_cat_pkg.sv
package seg_cat_pkg;
  parameter int LANES   = 4;
  parameter int NLANE_W = 4;
  parameter int WLANE_W = 8;
  localparam int NARROW_W = LANES * NLANE_W;
  localparam int WIDE_W   = LANES * WLANE_W;
  localparam int OUT_W    = NARROW_W + WIDE_W;
  localparam int MASK_W   = LANES - 1;
  localparam int POS_W    = $clog2(OUT_W);

  // Steering strobes: output bit offset of every lane of both operands
  typedef struct packed {
    logic [LANES-1:0][POS_W-1:0] nPos;
    logic [LANES-1:0][POS_W-1:0] wPos;
  } laneSteer_t;
endpackage

// File: rtl/seg_cat_ctrl.sv
module seg_cat_ctrl
  import seg_cat_pkg::*;
(
  input  logic [MASK_W-1:0] segMask,
  output laneSteer_t        steer
);
  localparam int PAIR_W = NLANE_W + WLANE_W;

  always_comb begin
    steer = '0;
    for (int i = 0; i < LANES; i++) begin
      int grpStart;
      int grpEnd;
      int grpLen;
      grpStart = 0;
      for (int j = 1; j < LANES; j++) begin
        if (j <= i && segMask[j-1]) grpStart = j;
      end
      grpEnd = LANES - 1;
      for (int k = LANES - 2; k >= 0; k--) begin
        if (k >= i && segMask[k]) grpEnd = k;
      end
      grpLen = grpEnd - grpStart + 1;
      steer.nPos[i] = POS_W'(grpStart * PAIR_W + (i - grpStart) * NLANE_W);
      steer.wPos[i] = POS_W'(grpStart * PAIR_W + grpLen * NLANE_W
                             + (i - grpStart) * WLANE_W);
    end
  end
endmodule

// File: rtl/seg_cat_dp.sv
module seg_cat_dp
  import seg_cat_pkg::*;
(
  input  logic [NARROW_W-1:0] narrowIn,
  input  logic [WIDE_W-1:0]   wideIn,
  input  laneSteer_t          steer,
  output logic [OUT_W-1:0]    catOut
);
  logic [LANES-1:0][OUT_W-1:0] nPlaced;
  logic [LANES-1:0][OUT_W-1:0] wPlaced;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign nPlaced[g] = OUT_W'(narrowIn[g*NLANE_W +: NLANE_W]) << steer.nPos[g];
    assign wPlaced[g] = OUT_W'(wideIn[g*WLANE_W +: WLANE_W]) << steer.wPos[g];
  end

  always_comb begin
    catOut = '0;
    for (int i = 0; i < LANES; i++) begin
      catOut = catOut | nPlaced[i] | wPlaced[i];
    end
  end
endmodule

// File: rtl/seg_cat.sv
module seg_cat
  import seg_cat_pkg::*;
(
  input  logic [15:0] narrowIn,
  input  logic [31:0] wideIn,
  input  logic [2:0]  segMask,
  output logic [47:0] catOut
);
  laneSteer_t steer;

  seg_cat_ctrl u_ctrl (
    .segMask (segMask),
    .steer   (steer)
  );

  seg_cat_dp u_dp (
    .narrowIn (narrowIn),
    .wideIn   (wideIn),
    .steer    (steer),
    .catOut   (catOut)
  );
endmodule

// File: rtl/seg_cat_chk.sv
module seg_cat_chk (
  input logic [15:0] narrowIn,
  input logic [31:0] wideIn,
  input logic [2:0]  segMask,
  input logic [47:0] catOut
);
  always_comb begin
    if (!$isunknown({narrowIn, wideIn, segMask, catOut})) begin
      AST_LOW_LANE_N0: assert (catOut[3:0] == narrowIn[3:0]); // R6
      AST_TOP_LANE_W3: assert (catOut[47:40] == wideIn[31:24]); // R7
      AST_ONES_KEPT: assert ($countones(catOut) == $countones(narrowIn) + $countones(wideIn)); // R8
      if (segMask == 3'b000) begin
        AST_SINGLE_GROUP: assert (catOut == {wideIn, narrowIn}); // R2
      end
      if (segMask == 3'b111) begin
        AST_FULL_SPLIT: assert (catOut == {wideIn[31:24], narrowIn[15:12], wideIn[23:16], narrowIn[11:8],
                                           wideIn[15:8], narrowIn[7:4], wideIn[7:0], narrowIn[3:0]}); // R3
      end
    end
  end
endmodule

bind seg_cat seg_cat_chk u_chk (
  .narrowIn (narrowIn),
  .wideIn   (wideIn),
  .segMask  (segMask),
  .catOut   (catOut)
);

// File: tb/seg_cat_bench.sv
module seg_cat_bench;
  logic        clk = 1'b0;
  logic [15:0] narrowIn;
  logic [31:0] wideIn;
  logic [2:0]  segMask;
  logic [47:0] catOut;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  seg_cat u_seg_cat (
    .narrowIn (narrowIn),
    .wideIn   (wideIn),
    .segMask  (segMask),
    .catOut   (catOut)
  );

  function automatic logic [47:0] refCat(logic [15:0] n, logic [31:0] w, logic [2:0] m);
    logic [47:0] y;
    int pos;
    int lane;
    y = '0;
    pos = 0;
    lane = 0;
    while (lane < 4) begin
      int len;
      len = 1;
      while (lane + len < 4 && !m[lane+len-1]) len++;
      for (int k = 0; k < len; k++) begin
        y = y | (48'(n[(lane+k)*4 +: 4]) << pos);
        pos += 4;
      end
      for (int k = 0; k < len; k++) begin
        y = y | (48'(w[(lane+k)*8 +: 8]) << pos);
        pos += 8;
      end
      lane += len;
    end
    return y;
  endfunction

  task automatic check(string req, logic [47:0] exp);
    checks++;
    if (catOut !== exp) begin
      fails++;
      $display("FAIL %s mask=%b n=%h w=%h actual=%h expected=%h",
               req, segMask, narrowIn, wideIn, catOut, exp);
    end
  endtask

  task automatic apply(logic [15:0] n, logic [31:0] w, logic [2:0] m);
    @(posedge clk);
    narrowIn = n;
    wideIn   = w;
    segMask  = m;
    @(negedge clk);
  endtask

  initial begin
    int seed;
    logic [15:0] nPat [6];
    logic [31:0] wPat [6];
    seed = 32'h5eed_0042;
    nPat = '{16'h0000, 16'hFFFF, 16'hAAAA, 16'h5555, 16'hDCBA, 16'h1F1F};
    wPat = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h5555_5555, 32'hAAAA_AAAA, 32'h1234_5678, 32'hF1F1_F1F1};

    // R9: all-zero inputs give an all-zero output
    apply(16'h0, 32'h0, 3'b000);
    check("R9 zero", 48'h0);

    // R2 single group
    apply(16'hDCBA, 32'h1234_5678, 3'b000);
    check("R2", 48'h1234_5678_DCBA);
    // R3 four groups
    apply(16'hDCBA, 32'h1234_5678, 3'b111);
    check("R3", 48'h12_D_34_C_56_B_78_A);
    // R4 two groups
    apply(16'hDCBA, 32'h1234_5678, 3'b010);
    check("R4", 48'h1234_DC_5678_BA);
    // R5 explicit, mask 001
    apply(16'hDCBA, 32'h1234_5678, 3'b001);
    check("R5 m001", 48'h123456_DCB_78_A);
    // R1: a boundary only at bit 2 groups lanes 0..2
    apply(16'hDCBA, 32'h1234_5678, 3'b100);
    check("R1 m100", 48'h12_D_345678_CBA);

    // R5 R6 R7 R8: every mask against directed patterns
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 6; p++) begin
        apply(nPat[p], wPat[p], 3'(m));
        check("R5 directed", refCat(nPat[p], wPat[p], 3'(m)));
        checks++;
        if (catOut[3:0] !== narrowIn[3:0] || catOut[47:40] !== wideIn[31:24]) begin
          fails++;
          $display("FAIL R6/R7 actual=%h expected low=%h high=%h", catOut, narrowIn[3:0], wideIn[31:24]);
        end
        checks++;
        if ($countones(catOut) != $countones(narrowIn) + $countones(wideIn)) begin
          fails++;
          $display("FAIL R8 actual=%0d expected=%0d", $countones(catOut),
                   $countones(narrowIn) + $countones(wideIn));
        end
      end
    end

    // R9: only the mask changes, and the output follows in the same cycle
    apply(16'hABCD, 32'h0123_4567, 3'b111);
    segMask = 3'b000;
    #0.5;
    check("R9 same cycle", 48'h0123_4567_ABCD);

    // R5: constrained random inputs
    void'($urandom(seed));
    for (int t = 0; t < 400; t++) begin
      logic [15:0] n;
      logic [31:0] w;
      n = 16'($urandom);
      w = $urandom;
      apply(n, w, 3'($urandom_range(7, 0)));
      check("R5 random", refCat(n, w, segMask));
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule